// File: doc/BRIEF.md
# Daisy-Chain Priority Interrupt Chain

This block collects interrupt requests from a fixed number of devices and arbitrates among them with a serial priority chain. Every device owns one identical stage. A stage remembers a request pulse from its device in a pending flag. Every stage contributes to one shared interrupt line toward the processor. The open-collector wiring of that line is modelled as a logical OR.

When the processor raises its acknowledge, the acknowledge enters the first stage as priority-in. A stage with no pending request passes priority on to its neighbour. The first stage in chain order that has a pending request keeps the priority for itself and places its vector address on the vector output. Stage 0 has the highest priority. Each stage's vector is computed from a base and a step parameter.

The processor's service routine clears a device's pending flag through that device's clear input. Requests that were blocked by a higher-priority stage stay pending. They are granted on a later acknowledge, once the stages ahead of them are clear.

Top module: `irq_daisy_chain`

## Requirements
- R1: After reset every pending flag is clear, so `int_req` is 0. With `ack` at 0 or 1, `vec_valid` is 0 and `vec_out` is 0.
- R2: A 1 on `dev_req[i]` at a rising clock edge, with `clr[i]` at 0, sets stage i's pending flag. `int_req` is 1 from that edge onward for as long as any pending flag is set.
- R3: A pending flag stays set until a clock edge at which its own `clr[i]` is 1. When `dev_req[i]` and `clr[i]` are both 1 at the same edge, the flag ends clear.
- R4: While `ack` is 0, `vec_valid` is 0 and `vec_out` is 0, whatever flags are pending.
- R5: While `ack` is 1 and at least one flag is pending, `vec_valid` is 1 in the same cycle. `vec_out` then carries the vector of the lowest-numbered pending stage. Stage i's vector is `VEC_BASE + i*VEC_STEP`, which is 0x20, 0x24, 0x28 and 0x2C by default.
- R6: At most one stage drives the vector bus in any cycle.
- R7: A request blocked by a lower-numbered pending stage stays pending after the acknowledge ends. It is granted on a later acknowledge once the stages ahead of it are cleared.
- R8: While `ack` is 1 and no flag is pending, the acknowledge passes through the whole chain unclaimed: `vec_valid` is 0 and `vec_out` is 0.
- R9: A 1 on `clr[j]` for a stage with no pending flag leaves every other stage's flag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| dev_req | input | NUM_DEV | Request pulse from each device; bit 0 has the highest priority |
| clr | input | NUM_DEV | Clear for each device's pending flag; takes precedence over a request in the same cycle |
| ack | input | 1 | Interrupt acknowledge from the processor; enters the first stage as priority-in |
| int_req | output | 1 | Shared interrupt request line (OR of all pending flags) |
| vec_out | output | VEC_W | Vector address of the granted stage; 0 when no stage is granted |
| vec_valid | output | 1 | High while a stage drives `vec_out` |

## Verification
The assertions check several properties in every cycle. At most one stage has its vector enable set. No vector appears without an acknowledge, and an acknowledge always yields a vector while a request is pending. `int_req` never rises without an unmasked request, and it never drops unless a clear was applied. A clear applied to all stages empties the line. Some properties cannot be expressed as cycle rules and are shown by the bench scenarios. These include which stage wins when several requests are pending together, the exact vector value it drives, and a blocked request staying pending through one acknowledge and then being granted on a later one. The bench scenarios also show clear winning over a simultaneous request, and a clear to an idle stage leaving the other stages untouched.

// File: rtl/irq_chain_pkg.sv
package irq_chain_pkg;

    // Registered state of one chain stage.
    typedef struct packed {
        logic pend;
    } stage_state_t;

endpackage

// File: rtl/irq_stage.sv
module irq_stage
    import irq_chain_pkg::*;
#(
    parameter int VEC_W   = 8,
    parameter int VEC_VAL = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_set,
    input  logic             req_clr,
    input  logic             pri_in,
    output logic             pri_out,
    output logic             pend,
    output logic             vec_en,
    output logic [VEC_W-1:0] vec_drv
);

    localparam logic [VEC_W-1:0] MY_VEC = VEC_W'(VEC_VAL);

    stage_state_t st_d, st_q;

    // Next state: set on request, clear wins over set.
    always_comb begin
        st_d = st_q;
        if (req_set) st_d.pend = 1'b1;
        if (req_clr) st_d.pend = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // Priority rule: no priority in -> nothing; priority with no
    // pending request -> forward; priority with pending -> claim.
    always_comb begin
        pend    = st_q.pend;
        pri_out = pri_in & ~st_q.pend;
        vec_en  = pri_in &  st_q.pend;
        vec_drv = vec_en ? MY_VEC : '0;
    end

endmodule

// File: rtl/irq_vec_merge.sv
module irq_vec_merge #(
    parameter int NUM_DEV = 4,
    parameter int VEC_W   = 8
) (
    input  logic [NUM_DEV-1:0][VEC_W-1:0] drv,
    input  logic [NUM_DEV-1:0]            en,
    output logic [VEC_W-1:0]              vec,
    output logic                          valid
);

    // Wired bus: OR of all driven vectors.
    always_comb begin
        vec   = '0;
        valid = 1'b0;
        for (int i = 0; i < NUM_DEV; i++) begin
            vec   = vec | drv[i];
            valid = valid | en[i];
        end
    end

endmodule

// File: rtl/irq_daisy_chain.sv
module irq_daisy_chain #(
    parameter int NUM_DEV  = 4,
    parameter int VEC_W    = 8,
    parameter int VEC_BASE = 32,
    parameter int VEC_STEP = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_DEV-1:0] dev_req,
    input  logic [NUM_DEV-1:0] clr,
    input  logic               ack,
    output logic               int_req,
    output logic [VEC_W-1:0]   vec_out,
    output logic               vec_valid
);

    logic [NUM_DEV:0]                chain_pri;
    logic [NUM_DEV-1:0]              stage_pend;
    logic [NUM_DEV-1:0]              stage_ven;
    logic [NUM_DEV-1:0][VEC_W-1:0]   stage_vec;

    assign chain_pri[0] = ack;

    for (genvar i = 0; i < NUM_DEV; i++) begin : g_stage
        localparam int STAGE_VEC = VEC_BASE + i * VEC_STEP;
        irq_stage #(
            .VEC_W  (VEC_W),
            .VEC_VAL(STAGE_VEC)
        ) u_stage (
            .clk    (clk),
            .rst_n  (rst_n),
            .req_set(dev_req[i]),
            .req_clr(clr[i]),
            .pri_in (chain_pri[i]),
            .pri_out(chain_pri[i+1]),
            .pend   (stage_pend[i]),
            .vec_en (stage_ven[i]),
            .vec_drv(stage_vec[i])
        );
    end

    // Shared request line: open-collector modelled as OR.
    assign int_req = |stage_pend;

    irq_vec_merge #(
        .NUM_DEV(NUM_DEV),
        .VEC_W  (VEC_W)
    ) u_merge (
        .drv  (stage_vec),
        .en   (stage_ven),
        .vec  (vec_out),
        .valid(vec_valid)
    );

endmodule

// File: rtl/irq_daisy_chain_chk.sv
module irq_daisy_chain_chk #(
    parameter int NUM_DEV = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_DEV-1:0] dev_req,
    input logic [NUM_DEV-1:0] clr,
    input logic               ack,
    input logic               int_req,
    input logic               vec_valid,
    input logic [NUM_DEV-1:0] stage_ven
);

    AST_ONE_DRIVER: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(stage_ven)); // R6

    AST_NO_ACK_NO_VEC: assert property (@(posedge clk) disable iff (!rst_n)
        !ack |-> !vec_valid); // R4

    AST_ACK_GETS_VEC: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && int_req) |-> vec_valid); // R5

    AST_EMPTY_NO_VEC: assert property (@(posedge clk) disable iff (!rst_n)
        !int_req |-> !vec_valid); // R8

    AST_RISE_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(int_req) |-> $past(|(dev_req & ~clr))); // R2

    AST_PEND_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (int_req && clr == '0) |=> int_req); // R3

    AST_CLR_ALL_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        (&clr) |=> !int_req); // R3

endmodule

bind irq_daisy_chain irq_daisy_chain_chk #(.NUM_DEV(NUM_DEV)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .dev_req  (dev_req),
    .clr      (clr),
    .ack      (ack),
    .int_req  (int_req),
    .vec_valid(vec_valid),
    .stage_ven(stage_ven)
);

// File: tb/tb_irq_daisy_chain.sv
module tb_irq_daisy_chain;

    localparam int N = 4;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] dev_req = '0;
    logic [N-1:0] clr = '0;
    logic         ack = 1'b0;
    logic         int_req;
    logic [W-1:0] vec_out;
    logic         vec_valid;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk; // 50 MHz

    irq_daisy_chain #(.NUM_DEV(N), .VEC_W(W), .VEC_BASE(32), .VEC_STEP(4)) dut (
        .clk(clk), .rst_n(rst_n), .dev_req(dev_req), .clr(clr), .ack(ack),
        .int_req(int_req), .vec_out(vec_out), .vec_valid(vec_valid)
    );

    // Vector of stage i per R5.
    function automatic int exp_vec(int i);
        return 32 + 4 * i;
    endfunction

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // Drive masks for exactly one rising edge; returns at a falling edge.
    task automatic pulse(logic [N-1:0] rq, logic [N-1:0] cl);
        @(negedge clk);
        dev_req = rq;
        clr     = cl;
        @(negedge clk);
        dev_req = '0;
        clr     = '0;
    endtask

    task automatic grant_is(string tag, int stage);
        ack = 1'b1;
        #1;
        chk({tag, " valid"}, vec_valid, 1);
        chk({tag, " vector"}, vec_out, exp_vec(stage));
        ack = 1'b0;
        #1;
    endtask

    task automatic t_reset();
        chk("R1 int_req", int_req, 0);
        chk("R1 valid ack=0", vec_valid, 0);
        ack = 1'b1;
        #1;
        chk("R1 valid ack=1", vec_valid, 0);
        chk("R1 vec ack=1", vec_out, 0);
        ack = 1'b0;
        #1;
    endtask

    task automatic t_single();
        pulse(4'b0100, 4'b0000);
        chk("R2 int_req after request", int_req, 1);
        chk("R4 no vector without ack", vec_valid, 0);
        chk("R4 vec zero without ack", vec_out, 0);
        repeat (3) @(negedge clk);
        chk("R3 flag held", int_req, 1);
        grant_is("R5 single stage 2", 2);
        pulse(4'b0000, 4'b0100);
        chk("R3 cleared", int_req, 0);
    endtask

    task automatic t_simul();
        pulse(4'b1010, 4'b0000);
        grant_is("R5 lowest index of 1,3", 1);
        chk("R7 blocked still pending", int_req, 1);
        pulse(4'b0000, 4'b0010);
        chk("R7 pending after clear of 1", int_req, 1);
        grant_is("R7 later grant stage 3", 3);
        pulse(4'b0000, 4'b1000);
        chk("R3 all clear", int_req, 0);
    endtask

    task automatic t_clr_wins();
        pulse(4'b0001, 4'b0001);
        chk("R3 clear beats set", int_req, 0);
        ack = 1'b1;
        #1;
        chk("R3 no grant after clear-win", vec_valid, 0);
        ack = 1'b0;
        #1;
    endtask

    task automatic t_clr_other();
        pulse(4'b0010, 4'b0000);
        pulse(4'b0000, 4'b0101);
        chk("R9 other flag kept", int_req, 1);
        grant_is("R9 stage 1 still granted", 1);
        pulse(4'b0000, 4'b0010);
    endtask

    task automatic t_empty_ack();
        ack = 1'b1;
        @(negedge clk);
        chk("R8 valid with no request", vec_valid, 0);
        chk("R8 vec with no request", vec_out, 0);
        ack = 1'b0;
        #1;
    endtask

    task automatic t_all();
        pulse(4'b1111, 4'b0000);
        for (int k = 0; k < N; k++) begin
            grant_is("R5 R7 walk", k);
            pulse(4'b0000, 4'(1 << k));
        end
        chk("R3 empty after walk", int_req, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_single();
        t_simul();
        t_clr_wins();
        t_clr_other();
        t_empty_ack();
        t_all();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule